// File: doc/BRIEF.md
# Bipolar Zero-Substitution Line Decoder

This block sits behind a clock-recovery stage. It takes dual-rail bipolar symbols, one per bit clock: a positive-pulse bit and a negative-pulse bit. It turns them back into a single NRZ data stream. The line encoder replaces long zero runs with short codes that contain a deliberate bipolar violation (V), sometimes preceded by a balancing pulse (B). The decoder finds those codes and restores the zeros. It supports two code families. The three-zero code serves the DS3 and STS-1 rates and the four-zero code serves the E3 rate.

While decoding, the block also watches the line for coding faults. A violation pulse that does not complete a valid substitution is a fault. So is a zero run longer than the active code permits, and so are pulses present on both rails at once. Each fault produces a one-bit-period pulse on a violation output, aligned with the output slot of the offending bit. A bypass setting treats the positive rail as plain NRZ data and suppresses all fault reporting.

Every bit leaves the block a fixed four bit clocks after it enters. That delay gives the decoder room to erase a balancing pulse that arrived before the violation which identifies it.

Top module: `zsd_line_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, data_o and lcv_o are 0 after that edge. A symbol sampled at clock edge k appears on data_o and lcv_o after edge k+4.
- R2: mode_i selects the code: 2'b00 is the three-zero code, 2'b01 is the four-zero code, and 2'b10 or 2'b11 is bypass. In a coded mode, a pulse on exactly one rail decodes to 1 and no pulse decodes to 0. A mark whose polarity alternates with the previous mark raises no violation.
- R3: In three-zero mode, two zero symbols followed by a mark with the same polarity as the previous mark (0 0 V) decode to three zeros without a violation.
- R4: In three-zero mode, a normal mark, a zero, and then a mark with the same polarity as that normal mark (B 0 V) decode to three zeros without a violation.
- R5: In four-zero mode, 0 0 0 V and B 0 0 V each decode to four zeros without a violation.
- R6: A same-polarity mark that does not end one of the active mode's substitution patterns raises lcv_o for that bit, and its data bit is 1. The first mark after reset is never a violation.
- R7: lcv_o is raised once per zero run, on the bit that completes the third consecutive zero in three-zero mode or the fourth in four-zero mode. Shorter runs raise nothing.
- R8: A symbol with both rails high decodes to 1, raises lcv_o, and leaves the remembered mark polarity unchanged.
- R9: In bypass, data_o equals pos_i delayed by four clocks, neg_i is ignored, and lcv_o stays 0.
- R10: Each fault makes lcv_o high for exactly the one output slot of the offending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Code select: 00 three-zero, 01 four-zero, 1x bypass |
| pos_i | input | 1 | Positive-pulse rail, or NRZ data in bypass |
| neg_i | input | 1 | Negative-pulse rail |
| data_o | output | 1 | Decoded NRZ data, four clocks after input |
| lcv_o | output | 1 | Line code violation pulse, aligned with data_o |

## Verification
The embedded assertions check several properties on every clock. Two back-to-back positive marks always count as a violation. Any pattern accepted as a substitution clears the violation pulse itself. A dual-rail symbol always enters the pipeline flagged. A zero-run pulse never repeats on the next clock unless the mode changed. After five clocks of bypass, the output mirrors the positive rail and shows no fault. Other behaviour appears only in the bench's scenarios. These include the erasure of a balancing pulse several clocks after it entered. They also include the different verdicts the two codes give on the same short pattern, and the exact output slot of each fault pulse.

// File: rtl/zsd_pkg.sv
// Shared types for the zero-substitution line decoder.
// Assumes mode encodings are fixed as listed; bit 1 set always means bypass.
package zsd_pkg;
    typedef enum logic [1:0] {
        ZS_THREE    = 2'b00,
        ZS_FOUR     = 2'b01,
        ZS_PASS     = 2'b10,
        ZS_PASS_ALT = 2'b11
    } zs_mode_e;

    function automatic logic zs_is_pass(input zs_mode_e m);
        return (m == ZS_PASS) || (m == ZS_PASS_ALT);
    endfunction

    function automatic logic zs_is_long(input zs_mode_e m);
        return (m == ZS_FOUR);
    endfunction
endpackage

// File: rtl/zsd_pulse_class.sv
// Classifies each incoming bipolar symbol.
// Outputs a single-rail mark, a dual-rail fault, and a same-polarity
// (violation) flag. It remembers the polarity of the last single-rail mark.
// Assumes one symbol per clock. The violation flag is combinational from the rails.
module zsd_pulse_class (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    output logic mark_o,
    output logic dual_o,
    output logic bpv_o
);
    logic last_pos_q;
    logic seen_q;

    // Decode the rail pair and compare polarity with the remembered mark
    always_comb begin
        mark_o = pos_i ^ neg_i;
        dual_o = pos_i & neg_i;
        bpv_o  = mark_o & seen_q & (pos_i == last_pos_q);
    end

    // Remember polarity of single-rail marks; dual-rail symbols leave it alone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pos_q <= 1'b0;
            seen_q     <= 1'b0;
        end else if (mark_o) begin
            last_pos_q <= pos_i;
            seen_q     <= 1'b1;
        end
    end

    // R6
    repeat_pos_is_bpv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i && !neg_i) ##1 (pos_i && !neg_i) |-> bpv_o);
endmodule

// File: rtl/zsd_run_watch.sv
// Counts consecutive zero symbols on the raw line. It pulses once when
// the run reaches the limit of the active code.
// Assumes the limit values fit in CNT_W bits. The counter saturates at the limit.
module zsd_run_watch #(
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 4,
    parameter int CNT_W     = $clog2(RUN_LONG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_i,
    input  logic zero_i,
    output logic hit_o
);
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(RUN_SHORT);
    localparam logic [CNT_W-1:0] LIM_L = CNT_W'(RUN_LONG);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Pick the run limit and flag the zero that reaches it
    always_comb begin
        limit = long_i ? LIM_L : LIM_S;
        hit_o = zero_i && (cnt_q == limit - CNT_W'(1));
    end

    // Track the length of the current zero run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!zero_i) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R7
    single_hit_per_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (!hit_o || (long_i != $past(long_i))));
endmodule

// File: rtl/zsd_subst_window.sv
// Delay line that holds the last DEPTH symbols. When a violation pulse
// completes a substitution, it erases the pulse and any balancing pulse
// still in the window. It also merges fault flags into a per-bit violation
// lane. Output latency is DEPTH clocks.
// Assumes DEPTH >= RUN_LONG - 1, so the balancing pulse is still held.
module zsd_subst_window #(
    parameter int DEPTH     = 4,
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_i,
    input  logic pass_i,
    input  logic pos_i,
    input  logic line_i,
    input  logic bpv_i,
    input  logic dual_i,
    input  logic hit_i,
    output logic data_o,
    output logic lcv_o
);
    logic [DEPTH-1:0] line_q, line_d;
    logic [DEPTH-1:0] mk_q, mk_d;
    logic [DEPTH-1:0] lv_q, lv_d;
    logic             pre_zero, mid_mark;
    logic             sub_plain, sub_bv, sub_bad;
    int               run_n;
    logic             data_q, lcv_q;

    // Match the zeros before the violation and test the balancing slot
    always_comb begin
        run_n    = long_i ? RUN_LONG : RUN_SHORT;
        pre_zero = 1'b1;
        mid_mark = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < run_n - 2) pre_zero = pre_zero & ~line_q[i];
            if (i == run_n - 2) mid_mark = line_q[i];
        end
        sub_plain = bpv_i & pre_zero & ~mid_mark;
        sub_bv    = bpv_i & pre_zero & mid_mark;
        sub_bad   = bpv_i & ~pre_zero;
    end

    // Build next window contents, erasing substituted pulses on the way
    always_comb begin
        line_d[0] = line_i;
        mk_d[0]   = pass_i ? pos_i : (line_i & ~(sub_plain | sub_bv));
        lv_d[0]   = ~pass_i & (dual_i | sub_bad | hit_i);
        for (int i = 1; i < DEPTH; i++) begin
            line_d[i] = line_q[i-1];
            mk_d[i]   = mk_q[i-1] & ~(~pass_i & sub_bv & ((i - 1) == (run_n - 2)));
            lv_d[i]   = lv_q[i-1];
        end
    end

    // Advance the window by one symbol
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            mk_q   <= '0;
            lv_q   <= '0;
        end else begin
            line_q <= line_d;
            mk_q   <= mk_d;
            lv_q   <= lv_d;
        end
    end

    // Register the oldest slot onto the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 1'b0;
            lcv_q  <= 1'b0;
        end else begin
            data_q <= mk_q[DEPTH-1];
            lcv_q  <= lv_q[DEPTH-1];
        end
    end

    assign data_o = data_q;
    assign lcv_o  = lcv_q;

    // R3 R4 R5
    subst_erases_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_i && (sub_plain || sub_bv)) |=> (!mk_q[0] && !lv_q[0]));

    // R8
    dual_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_i && dual_i) |=> (mk_q[0] && lv_q[0]));
endmodule

// File: rtl/zsd_line_decoder.sv
// Top of the bipolar zero-substitution line decoder. It wires the symbol
// classifier, the zero-run watcher and the substitution window.
// Assumes one dual-rail symbol per clock. Mode changes take effect at once;
// bits already inside the window keep the result they had.
module zsd_line_decoder
    import zsd_pkg::*;
#(
    parameter int RUN_SHORT = 3,
    parameter int RUN_LONG  = 4,
    parameter int LAT       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       pos_i,
    input  logic       neg_i,
    output logic       data_o,
    output logic       lcv_o
);
    localparam int CNT_W = $clog2(RUN_LONG + 1);

    zs_mode_e mode;
    logic     pass, long_code;
    logic     mark, dual, bpv, hit;

    // Decode the mode select
    always_comb begin
        mode      = zs_mode_e'(mode_i);
        pass      = zs_is_pass(mode);
        long_code = zs_is_long(mode);
    end

    zsd_pulse_class u_class (
        .clk    (clk),
        .rst_n  (rst_n),
        .pos_i  (pos_i),
        .neg_i  (neg_i),
        .mark_o (mark),
        .dual_o (dual),
        .bpv_o  (bpv)
    );

    zsd_run_watch #(
        .RUN_SHORT (RUN_SHORT),
        .RUN_LONG  (RUN_LONG),
        .CNT_W     (CNT_W)
    ) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .long_i (long_code),
        .zero_i (~(pos_i | neg_i)),
        .hit_o  (hit)
    );

    zsd_subst_window #(
        .DEPTH     (LAT),
        .RUN_SHORT (RUN_SHORT),
        .RUN_LONG  (RUN_LONG)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .long_i (long_code),
        .pass_i (pass),
        .pos_i  (pos_i),
        .line_i (mark | dual),
        .bpv_i  (bpv),
        .dual_i (dual),
        .hit_i  (hit),
        .data_o (data_o),
        .lcv_o  (lcv_o)
    );

    // Count consecutive bypass clocks for the pass-through check
    logic [2:0] pass_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !pass) begin
            pass_run_q <= 3'd0;
        end else if (pass_run_q != 3'd7) begin
            pass_run_q <= pass_run_q + 3'd1;
        end
    end

    if (LAT == 4) begin : g_pass_chk
        // R9
        bypass_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pass_run_q >= 3'd5) |-> ((data_o == $past(pos_i, 5)) && !lcv_o));
    end
endmodule

// File: tb/zsd_line_decoder_tb_top.sv
`timescale 1ns/1ps
module zsd_line_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       pos_i = 1'b0;
    logic       neg_i = 1'b0;
    logic       data_o, lcv_o;

    always #2 clk = ~clk;

    zsd_line_decoder dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .pos_i  (pos_i),
        .neg_i  (neg_i),
        .data_o (data_o),
        .lcv_o  (lcv_o)
    );

    typedef struct {
        int    due;
        logic  d;
        logic  l;
        string tag;
        bit    chk;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare outputs against items whose slot has arrived
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.chk && e.due == cyc) begin
                n_cmp++;
                if (data_o !== e.d || lcv_o !== e.l) begin
                    n_bad++;
                    $display("FAIL %s: cycle %0d data/lcv actual %b/%b expected %b/%b",
                             e.tag, cyc, data_o, lcv_o, e.d, e.l);
                end
            end
        end
    end

    // Driver: apply a symbol and queue its expected output four edges later
    task automatic sym(input logic p, input logic n, input logic ed,
                       input logic el, input string tag, input bit chk = 1);
        exp_t e;
        @(negedge clk);
        #1;
        pos_i = p;
        neg_i = n;
        e.due = cyc + 5;
        e.d   = ed;
        e.l   = el;
        e.tag = tag;
        e.chk = chk;
        q.push_back(e);
    endtask

    task automatic drain();
        for (int i = 0; i < 7; i++) sym(1'b0, 1'b0, 1'b0, 1'b0, "", 0);
    endtask

    task automatic restart(input logic [1:0] m);
        @(negedge clk);
        #1;
        rst_n  = 1'b0;
        mode_i = m;
        pos_i  = 1'b0;
        neg_i  = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(100000 * 4);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual running expected done");
        summary();
    end

    initial begin
        // R1: outputs held at zero under reset even with line activity
        rst_n = 1'b0;
        pos_i = 1'b1;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (data_o !== 1'b0 || lcv_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: reset data/lcv actual %b/%b expected 0/0", data_o, lcv_o);
        end

        // R2 R1: plain alternating marks, three-zero mode
        restart(2'b00);
        sym(1,0, 1,0, "R2"); sym(0,0, 0,0, "R2"); sym(0,1, 1,0, "R2");
        sym(0,0, 0,0, "R2"); sym(1,0, 1,0, "R2"); sym(0,1, 1,0, "R2");
        drain();

        // R3: 0 0 V
        restart(2'b00);
        sym(1,0, 1,0, "R3"); sym(0,0, 0,0, "R3"); sym(0,0, 0,0, "R3");
        sym(1,0, 0,0, "R3"); sym(0,1, 1,0, "R3");
        drain();

        // R4: B 0 V, balancing pulse erased afterwards
        restart(2'b00);
        sym(1,0, 1,0, "R4"); sym(0,1, 0,0, "R4"); sym(0,0, 0,0, "R4");
        sym(0,1, 0,0, "R4"); sym(1,0, 1,0, "R4");
        drain();

        // R6 R10: bare violation, three-zero mode
        restart(2'b00);
        sym(1,0, 1,0, "R6"); sym(0,1, 1,0, "R6"); sym(0,1, 1,1, "R6");
        sym(1,0, 1,0, "R10");
        drain();

        // R7 R10: zero run in three-zero mode flagged once
        restart(2'b00);
        sym(1,0, 1,0, "R7"); sym(0,0, 0,0, "R7"); sym(0,0, 0,0, "R7");
        sym(0,0, 0,1, "R7"); sym(0,0, 0,0, "R10"); sym(0,1, 1,0, "R7");
        drain();

        // R8: dual-rail symbol keeps polarity
        restart(2'b00);
        sym(1,0, 1,0, "R8"); sym(1,1, 1,1, "R8"); sym(0,1, 1,0, "R8");
        sym(0,1, 1,1, "R8");
        drain();

        // R5: 0 0 0 V, four-zero mode
        restart(2'b01);
        sym(1,0, 1,0, "R5"); sym(0,0, 0,0, "R5"); sym(0,0, 0,0, "R5");
        sym(0,0, 0,0, "R5"); sym(1,0, 0,0, "R5"); sym(0,1, 1,0, "R5");
        drain();

        // R5: B 0 0 V, four-zero mode
        restart(2'b01);
        sym(1,0, 1,0, "R5"); sym(0,1, 0,0, "R5"); sym(0,0, 0,0, "R5");
        sym(0,0, 0,0, "R5"); sym(0,1, 0,0, "R5"); sym(1,0, 1,0, "R5");
        drain();

        // R6: pattern valid as B0V in three-zero mode is a fault in four-zero mode
        restart(2'b01);
        sym(1,0, 1,0, "R6"); sym(0,0, 0,0, "R6"); sym(1,0, 1,1, "R6");
        drain();

        // R7: three zeros allowed, four flagged, four-zero mode
        restart(2'b01);
        sym(1,0, 1,0, "R7"); sym(0,0, 0,0, "R7"); sym(0,0, 0,0, "R7");
        sym(0,0, 0,0, "R7"); sym(0,1, 1,0, "R7"); sym(0,0, 0,0, "R7");
        sym(0,0, 0,0, "R7"); sym(0,0, 0,0, "R7"); sym(0,0, 0,1, "R7");
        sym(1,0, 1,0, "R7");
        drain();

        // R9: bypass mirrors positive rail, no faults
        restart(2'b11);
        sym(1,1, 1,0, "R9"); sym(0,1, 0,0, "R9"); sym(0,0, 0,0, "R9");
        sym(0,0, 0,0, "R9"); sym(0,0, 0,0, "R9"); sym(0,0, 0,0, "R9");
        sym(1,0, 1,0, "R9"); sym(1,1, 1,0, "R9"); sym(1,0, 1,0, "R9");
        drain();
        restart(2'b10);
        sym(1,0, 1,0, "R9"); sym(1,0, 1,0, "R9"); sym(0,1, 0,0, "R9");
        drain();

        wait (q.size() == 0);
        @(negedge clk);
        summary();
    end
endmodule